// File: doc/BRIEF.md
# Tri-Level Control Line Step Decoder

This block sits behind the comparators that watch a single three-level adjustment line and turns that line into clean step commands for a setting counter. At rest the line floats at mid level. Pulling it low asks for one increment. Driving it high asks for one decrement. Each departure from mid must last long enough before it counts, and the line must come back to mid before the next request can be seen. The block emits one-cycle `inc_o` or `dec_o` strobes that a separate counter consumes.

Three comparator flags come in asynchronously: line above the high threshold, line below the low threshold, and line above the program threshold. All three pass through a two-flop synchronizer. The program flag also goes out again as `prog_o` for a separate storage controller. All widths and timings are parameters: the qualification width and the minimum spacing between counts are given in microseconds and converted to clock cycles from a clock-frequency parameter. With the defaults (1 MHz, 100 us, 10 us) this gives Q = 100 and S = 10 cycles.

The first qualified request after reset is discarded, because the comparators may start in an unknown state. Requests are honoured only while `enable_i` is high.

Top module: `tristate_step_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `inc_o`, `dec_o` and `prog_o` are 0.
- R2: A low excursion (`below_lo_i`=1, others 0) held for at least Q input cycles gives exactly one `inc_o` pulse. The pulse is visible Q+2 clock cycles after the cycle in which the excursion was first driven.
- R3: A high excursion (`above_hi_i`=1, `above_prog_i`=0) held for at least Q cycles gives exactly one `dec_o` pulse, with the same Q+2 latency.
- R4: An excursion held for Q-1 cycles or fewer produces no strobe. This covers every pulse shorter than 20 us.
- R5: A floating line (all three flags 0) produces no strobe, however long it stays there.
- R6: After a strobe, no excursion starts counting until the spacing timer of S cycles, loaded one cycle after the strobe, has expired. An excursion that starts earlier is discarded whole. Two strobes are never closer than S cycles.
- R7: A single excursion yields at most one strobe, however long it lasts. The line must return to mid before another excursion is counted.
- R8: The first excursion after reset that qualifies while `enable_i` is high produces no strobe.
- R9: Taking `enable_i` low and then high again does not re-arm the discard rule of R8.
- R10: While `enable_i` is low, no strobe is produced, and an excursion in progress is abandoned.
- R11: `prog_o` follows `above_prog_i` with a two-cycle delay. A high excursion whose synchronized program flag is 1 at the qualifying cycle produces no `dec_o`.
- R12: `inc_o` and `dec_o` are never high together, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Adjustment enable; strobes only while high |
| above_hi_i | input | 1 | Asynchronous flag: line above the high threshold |
| below_lo_i | input | 1 | Asynchronous flag: line below the low threshold |
| above_prog_i | input | 1 | Asynchronous flag: line above the program threshold |
| inc_o | output | 1 | One-cycle increment strobe |
| dec_o | output | 1 | One-cycle decrement strobe |
| prog_o | output | 1 | Synchronized program-level flag |

## Verification
Two functions can land in the same cycle: a high excursion reaching its qualification count, and the synchronized program flag rising. The bench drives a high excursion and raises the program flag exactly Q-1 input cycles after the excursion starts. The synchronized flag then reaches the decision logic in the qualifying cycle itself, and the bench expects no decrement. A second run raises the flag one cycle later; there the decrement has already been issued, and the bench expects exactly one. A similar collision between the spacing timer and a new excursion is checked with mid gaps of S and S+1 cycles.

// File: rtl/tpd_pkg.sv
// Package: shared types for the tri-level step decoder.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tpd_pkg;

    // Which side of the mid rest level the line currently sits on
    typedef enum logic [1:0] {
        SIDE_MID  = 2'd0,
        SIDE_LOW  = 2'd1,
        SIDE_HIGH = 2'd2
    } side_e;

    // Qualification state machine states
    typedef enum logic [1:0] {
        ST_WAIT_MID = 2'd0,
        ST_IDLE     = 2'd1,
        ST_RUN      = 2'd2
    } qual_state_e;

endpackage

// File: rtl/tpd_sync.sv
// Module: tpd_sync
// Two-flop synchronizer for WIDTH independent asynchronous flags.
// Assumes each flag is a level that stays put for several clocks,
// so bits need no mutual coherence.
module tpd_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stable_q;

        // Two-stage capture of one asynchronous flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_i[g];
                stable_q <= meta_q;
            end
        end

        assign sync_o[g] = stable_q;
    end
endmodule

// File: rtl/tpd_level_decode.sv
// Module: tpd_level_decode
// Maps the synchronized comparator flags to a line side.
// A line above the program threshold counts as high. A contradictory
// pattern (low together with high) is treated as mid, so it never counts.
module tpd_level_decode
    import tpd_pkg::*;
(
    input  logic  hi_s_i,
    input  logic  lo_s_i,
    input  logic  prog_s_i,
    output side_e side_o
);
    logic high_any;

    // Classify the line level
    always_comb begin
        high_any = hi_s_i | prog_s_i;
        if (lo_s_i && !high_any)      side_o = SIDE_LOW;
        else if (high_any && !lo_s_i) side_o = SIDE_HIGH;
        else                          side_o = SIDE_MID;
    end
endmodule

// File: rtl/tpd_gap_timer.sv
// Module: tpd_gap_timer
// Counts down SPACE_CYC cycles after each strobe. busy_o is high while
// the count is nonzero. Assumes SPACE_CYC >= 1.
module tpd_gap_timer #(
    parameter int SPACE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic busy_o
);
    localparam int GW = $clog2(SPACE_CYC + 1);

    logic [GW-1:0] left_q;

    // Reload on a strobe, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                left_q <= '0;
        else if (fire_i)           left_q <= GW'(SPACE_CYC);
        else if (left_q != '0)     left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);
endmodule

// File: rtl/tpd_width_fsm.sv
// Module: tpd_width_fsm
// Measures each excursion away from mid and issues one-cycle strobes.
// An excursion qualifies after QUAL_CYC consecutive samples on one side.
// The first qualification after reset is swallowed. Assumes QUAL_CYC >= 2.
module tpd_width_fsm
    import tpd_pkg::*;
#(
    parameter int QUAL_CYC = 100
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable_i,
    input  side_e side_i,
    input  logic  prog_s_i,
    input  logic  gap_busy_i,
    output logic  inc_o,
    output logic  dec_o
);
    localparam int CW = $clog2(QUAL_CYC + 1);

    qual_state_e   state_q;
    side_e         dir_q;
    logic [CW-1:0] cnt_q;
    logic          first_pend_q;

    // Excursion tracking, qualification and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_WAIT_MID;
            dir_q        <= SIDE_MID;
            cnt_q        <= '0;
            first_pend_q <= 1'b1;
            inc_o        <= 1'b0;
            dec_o        <= 1'b0;
        end else begin
            inc_o <= 1'b0;
            dec_o <= 1'b0;
            case (state_q)
                ST_WAIT_MID: begin
                    if (side_i == SIDE_MID) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (side_i != SIDE_MID) begin
                        if (enable_i && !gap_busy_i) begin
                            state_q <= ST_RUN;
                            dir_q   <= side_i;
                            cnt_q   <= CW'(1);
                        end else begin
                            state_q <= ST_WAIT_MID;
                        end
                    end
                end
                ST_RUN: begin
                    if (!enable_i) begin
                        state_q <= ST_WAIT_MID;
                    end else if (side_i != dir_q) begin
                        state_q <= (side_i == SIDE_MID) ? ST_IDLE : ST_WAIT_MID;
                    end else if (cnt_q == CW'(QUAL_CYC - 1)) begin
                        state_q <= ST_WAIT_MID;
                        if (first_pend_q)           first_pend_q <= 1'b0;
                        else if (dir_q == SIDE_LOW) inc_o <= 1'b1;
                        else if (!prog_s_i)         dec_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_WAIT_MID;
            endcase
        end
    end
endmodule

// File: rtl/tristate_step_decoder.sv
// Module: tristate_step_decoder (top)
// Turns three asynchronous comparator flags from a tri-level adjustment
// line into one-cycle increment/decrement strobes, and passes the
// program-level flag on. Durations are given in microseconds and
// converted to cycles; assumes CLK_HZ is a multiple of 1 MHz.
module tristate_step_decoder
    import tpd_pkg::*;
#(
    parameter int CLK_HZ   = 1_000_000,
    parameter int QUAL_US  = 100,
    parameter int SPACE_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic above_hi_i,
    input  logic below_lo_i,
    input  logic above_prog_i,
    output logic inc_o,
    output logic dec_o,
    output logic prog_o
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int QUAL_CYC   = QUAL_US * CYC_PER_US;
    localparam int SPACE_CYC  = SPACE_US * CYC_PER_US;

    logic [2:0] flags_s;
    side_e      side;
    logic       gap_busy;
    logic       inc_int;
    logic       dec_int;

    tpd_sync #(.WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({above_prog_i, below_lo_i, above_hi_i}),
        .sync_o  (flags_s)
    );

    tpd_level_decode u_level (
        .hi_s_i   (flags_s[0]),
        .lo_s_i   (flags_s[1]),
        .prog_s_i (flags_s[2]),
        .side_o   (side)
    );

    tpd_gap_timer #(.SPACE_CYC(SPACE_CYC)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (inc_int | dec_int),
        .busy_o (gap_busy)
    );

    tpd_width_fsm #(.QUAL_CYC(QUAL_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .side_i     (side),
        .prog_s_i   (flags_s[2]),
        .gap_busy_i (gap_busy),
        .inc_o      (inc_int),
        .dec_o      (dec_int)
    );

    assign inc_o  = inc_int;
    assign dec_o  = dec_int;
    assign prog_o = flags_s[2];
endmodule

// File: rtl/tpd_checker.sv
// Module: tpd_checker
// Property checks for tristate_step_decoder, bound to the top below.
// Assumes a synchronous active-low reset.
module tpd_checker #(
    parameter int SPACE_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic inc_o,
    input logic dec_o,
    input logic prog_o
);
    localparam int SW = $clog2(SPACE_CYC + 1);

    logic [SW-1:0] since_q;

    // Cycles since the last strobe, saturating at SPACE_CYC
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_q <= SW'(SPACE_CYC);
        else if (inc_o || dec_o)            since_q <= '0;
        else if (since_q != SW'(SPACE_CYC)) since_q <= since_q + 1'b1;
    end

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_o && dec_o));

    assert_inc_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |=> !inc_o);

    assert_dec_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o |=> !dec_o);

    assert_inc_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inc_o) |-> $past(enable_i));

    assert_dec_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_o) |-> $past(enable_i));

    assert_dec_not_prog_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_o) |-> !$past(prog_o));

    assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_o || dec_o) |-> (since_q == SW'(SPACE_CYC)));
endmodule

bind tristate_step_decoder tpd_checker #(.SPACE_CYC(SPACE_CYC)) u_tpd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .inc_o    (inc_o),
    .dec_o    (dec_o),
    .prog_o   (prog_o)
);

// File: tb/tristate_step_decoder_bench.sv
`timescale 1ns/1ps
module tristate_step_decoder_bench;
    localparam int Q = 100;
    localparam int S = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic above_hi_i = 1'b0;
    logic below_lo_i = 1'b0;
    logic above_prog_i = 1'b0;
    logic inc_o, dec_o, prog_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int inc_cnt = 0;
    int dec_cnt = 0;
    int last_inc = -1;
    int last_dec = -1;
    logic prev_inc = 1'b0;
    logic prev_dec = 1'b0;
    bit   done = 1'b0;

    tristate_step_decoder #(.CLK_HZ(1_000_000), .QUAL_US(100), .SPACE_US(10))
        u_tristate_step_decoder (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .above_hi_i(above_hi_i), .below_lo_i(below_lo_i),
        .above_prog_i(above_prog_i),
        .inc_o(inc_o), .dec_o(dec_o), .prog_o(prog_o));

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Count strobes and watch R12 at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (inc_o) begin inc_cnt++; last_inc = cyc; end
            if (dec_o) begin dec_cnt++; last_dec = cyc; end
            checks++;
            if ((inc_o && dec_o) || (inc_o && prev_inc) || (dec_o && prev_dec)) begin
                fails++;
                $display("FAIL R12: inc=%0b dec=%0b prev_inc=%0b prev_dec=%0b expected single exclusive strobes",
                         inc_o, dec_o, prev_inc, prev_dec);
            end
            prev_inc = inc_o;
            prev_dec = dec_o;
        end
    end

    function automatic bool_qualifies(input int len);
        return (len >= Q);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // side: 0 low, 1 high; returns start cycle
    task automatic excursion(input int side, input int len, input int gap, output int start);
        @(negedge clk);
        start = cyc;
        if (side == 0) below_lo_i = 1'b1; else above_hi_i = 1'b1;
        repeat (len) @(negedge clk);
        below_lo_i = 1'b0;
        above_hi_i = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int st, i0, d0, exp_i, exp_d;
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        repeat (5) @(negedge clk);
        check(!inc_o && !dec_o && !prog_o, "R1", {inc_o, dec_o, prog_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!inc_o && !dec_o && !prog_o, "R1", {inc_o, dec_o, prog_o}, 0);
        enable_i = 1'b1;
        repeat (10) @(negedge clk);

        // R8: first qualified excursion swallowed
        excursion(0, Q, 30, st);
        check(inc_cnt == 0, "R8", inc_cnt, 0);

        // R2: increment with exact latency
        excursion(0, Q, 30, st);
        check(inc_cnt == 1, "R2", inc_cnt, 1);
        check(last_inc == st + Q + 2, "R2", last_inc, st + Q + 2);

        // R3: decrement with exact latency
        excursion(1, Q, 30, st);
        check(dec_cnt == 1, "R3", dec_cnt, 1);
        check(last_dec == st + Q + 2, "R3", last_dec, st + Q + 2);

        // R4: too short, including the 20 us class
        excursion(0, Q - 1, 30, st);
        excursion(1, Q - 1, 30, st);
        excursion(0, 19, 30, st);
        check(inc_cnt == 1 && dec_cnt == 1, "R4", inc_cnt + dec_cnt, 2);

        // R5: floating line
        repeat (300) @(negedge clk);
        check(inc_cnt == 1 && dec_cnt == 1, "R5", inc_cnt + dec_cnt, 2);

        // R7: long hold counts once
        excursion(0, 3 * Q, 30, st);
        check(inc_cnt == 2, "R7", inc_cnt, 2);

        // R6: spacing collision, gap S rejected, gap S+1 accepted
        excursion(0, Q, S, st);
        excursion(0, Q, 30, st);
        check(inc_cnt == 3, "R6", inc_cnt, 3);
        excursion(0, Q, S + 1, st);
        excursion(0, Q, 30, st);
        check(inc_cnt == 5, "R6", inc_cnt, 5);

        // R10: enable low ignores excursions, and an abandoned one
        enable_i = 1'b0;
        excursion(0, Q, 30, st);
        excursion(1, Q, 30, st);
        check(inc_cnt == 5 && dec_cnt == 1, "R10", inc_cnt + dec_cnt, 6);
        enable_i = 1'b1;
        @(negedge clk);
        below_lo_i = 1'b1;
        repeat (Q / 2) @(negedge clk);
        enable_i = 1'b0;
        repeat (Q) @(negedge clk);
        enable_i = 1'b1;
        repeat (Q) @(negedge clk);
        below_lo_i = 1'b0;
        repeat (30) @(negedge clk);
        check(inc_cnt == 5, "R10", inc_cnt, 5);

        // R9: enable toggle does not re-arm the first-pulse rule
        excursion(0, Q, 30, st);
        check(inc_cnt == 6, "R9", inc_cnt, 6);

        // R11: program flag pass-through and suppression
        @(negedge clk);
        above_hi_i = 1'b1;
        above_prog_i = 1'b1;
        @(negedge clk);
        check(prog_o == 1'b0, "R11", prog_o, 0);
        @(negedge clk);
        check(prog_o == 1'b1, "R11", prog_o, 1);
        repeat (Q + 10) @(negedge clk);
        above_hi_i = 1'b0;
        above_prog_i = 1'b0;
        repeat (30) @(negedge clk);
        check(dec_cnt == 1, "R11", dec_cnt, 1);
        check(prog_o == 1'b0, "R11", prog_o, 0);

        // R11 corner: flag reaches the decision in the qualifying cycle
        @(negedge clk);
        above_hi_i = 1'b1;
        repeat (Q - 1) @(negedge clk);
        above_prog_i = 1'b1;
        repeat (10) @(negedge clk);
        above_hi_i = 1'b0;
        above_prog_i = 1'b0;
        repeat (30) @(negedge clk);
        check(dec_cnt == 1, "R11", dec_cnt, 1);
        // One cycle later: decrement already issued
        @(negedge clk);
        above_hi_i = 1'b1;
        repeat (Q) @(negedge clk);
        above_prog_i = 1'b1;
        repeat (10) @(negedge clk);
        above_hi_i = 1'b0;
        above_prog_i = 1'b0;
        repeat (30) @(negedge clk);
        check(dec_cnt == 2, "R11", dec_cnt, 2);

        // R2 R3 R4: random excursions against bench expectation
        i0 = inc_cnt;
        d0 = dec_cnt;
        exp_i = 0;
        exp_d = 0;
        for (int n = 0; n < 60; n++) begin
            int side, len, gap;
            side = int'($urandom_range(1, 0));
            len  = int'($urandom_range(Q + 20, Q - 20));
            gap  = int'($urandom_range(S + 30, S + 2));
            if (bool_qualifies(len)) begin
                if (side == 0) exp_i++; else exp_d++;
            end
            excursion(side, len, gap, st);
        end
        repeat (10) @(negedge clk);
        check(inc_cnt - i0 == exp_i, "R2", inc_cnt - i0, exp_i);
        check(dec_cnt - d0 == exp_d, "R3", dec_cnt - d0, exp_d);

        finish_up();
    end
endmodule